// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the software-visible register bank of a colour LCD controller. It sits on a simple 32-bit bus addressed by word, with one-cycle read and write strobes. It holds four display timing words, two frame base addresses, a control word, an interrupt mask and a raw interrupt status with write-one-to-clear semantics. A read-only identification window sits at the top of the 4 KiB space. A two-bit variant input selects which of three register layouts the bank presents.

From the stored words the bank decodes the active width and height, the pixel-depth code and a display-enable flag. These go to the pixel fetch and video timing logic, which live outside this block. Status bits are set by one event input per bit. An interrupt line rises whenever a status bit is set and also unmasked.

The bus has no back-pressure, because every register access completes in a fixed time. A write takes effect at the clock edge where the write strobe is sampled. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every stored register reads zero. The decoded outputs are then width 16, height 1, depth code 0, display disabled, and the interrupt line low.
- R2: Word indices 0 to 3 (address bits [11:2]) are the timing words, index 4 is the upper frame base and index 5 is the lower frame base; all read back what was written. Indices 11 and 12 read the upper and lower base respectively.
- R3: With variant 0, index 6 is the interrupt mask and index 7 is control. With variant 1, 2 or 3 the two indices are swapped, for both reads and writes.
- R4: Active width equals ((timing0 & 0xFC) + 4) * 4. Active height equals (timing1 & 0x3FF) + 1. Both follow each write to their timing word.
- R5: The depth code output is control bits [3:1]. The display-enable output is high only when control bit 0 and control bit 11 are both 1.
- R6: A 1 on an event input bit sets that raw status bit. A write to index 10 clears every raw bit where the written data holds a 1. An event in the same cycle as a clear wins, so the bit stays set.
- R7: Index 8 reads the raw status and index 9 reads raw AND mask, both in the low IRQ_W bits. The interrupt output is high exactly when raw AND mask is nonzero.
- R8: Indices 0x3F8 to 0x3FF return one identification byte each. Variant 2 returns 0x11,0x11,0x24,0x00,0x0D,0xF0,0x05,0xB1. Every other variant returns 0x10,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1.
- R9: Reads of unmapped indices return zero. Writes to unmapped indices, to the status indices 8 and 9, and to the identification window change nothing.
- R10: Read data is registered. It shows the addressed value in the cycle after the read strobe and holds its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address; bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| variant | input | 2 | Register layout select |
| irq_event | input | IRQ_W (4) | Per-bit status set pulses |
| irq_out | output | 1 | Interrupt, high while any unmasked status bit is set |
| act_width | output | 11 | Decoded active width in pixels |
| act_height | output | 11 | Decoded active height in lines |
| bpp_code | output | 3 | Pixel-depth code |
| disp_en | output | 1 | Display enabled flag |

## Verification
The assertions assume that write and read strobes are never given together and that the variant input is changed only while the bus is idle. They also assume that event pulses coincide with a clear write only when the test means to exercise the event-wins rule. The bench drives every access through write and read tasks that assert exactly one strobe for one cycle. It changes the variant only between accesses. It raises events only in dedicated steps, with a single step that deliberately overlaps an event with a clear. Geometry, control and status are swept exhaustively over all relevant field values, and expected results are computed arithmetically.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;

  localparam int GEOM_W = 11;

  localparam int IDX_TIM0  = 0;
  localparam int IDX_UPB   = 4;
  localparam int IDX_LPB   = 5;
  localparam int IDX_SLOTA = 6;
  localparam int IDX_SLOTB = 7;
  localparam int IDX_RAW   = 8;
  localparam int IDX_MSK   = 9;
  localparam int IDX_CLR   = 10;
  localparam int IDX_UPCUR = 11;
  localparam int IDX_LPCUR = 12;

  typedef struct packed {
    logic [3:0] tim;
    logic       upb;
    logic       lpb;
    logic       imask;
    logic       ctrl;
    logic       raw;
    logic       msk;
    logic       clr;
    logic       upcur;
    logic       lpcur;
    logic       id;
    logic [2:0] id_n;
  } sel_t;

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] n);
    case (n)
      3'd0:    id_byte = ext ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = ext ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_regs_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       variant,
  output sel_t             sel
);

  logic swap;
  assign swap = (variant != 2'd0);

  always_comb begin
    sel = '0;
    if (&idx[IDX_W-1:3]) begin
      sel.id   = 1'b1;
      sel.id_n = idx[2:0];
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (idx == IDX_W'(IDX_TIM0 + i)) sel.tim[i] = 1'b1;
      end
      if (idx == IDX_W'(IDX_UPB))   sel.upb   = 1'b1;
      if (idx == IDX_W'(IDX_LPB))   sel.lpb   = 1'b1;
      if (idx == IDX_W'(IDX_SLOTA)) begin
        if (swap) sel.ctrl = 1'b1;
        else      sel.imask = 1'b1;
      end
      if (idx == IDX_W'(IDX_SLOTB)) begin
        if (swap) sel.imask = 1'b1;
        else      sel.ctrl = 1'b1;
      end
      if (idx == IDX_W'(IDX_RAW))   sel.raw   = 1'b1;
      if (idx == IDX_W'(IDX_MSK))   sel.msk   = 1'b1;
      if (idx == IDX_W'(IDX_CLR))   sel.clr   = 1'b1;
      if (idx == IDX_W'(IDX_UPCUR)) sel.upcur = 1'b1;
      if (idx == IDX_W'(IDX_LPCUR)) sel.lpcur = 1'b1;
    end
  end

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_bits,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);

  logic [IRQ_W-1:0] kill;
  assign kill = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~kill) | evt;
      if (mask_we) mask_q <= mask_bits;
    end
  end

  assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_regs_pkg::*;
(
  input  logic [5:0]        wfield,
  input  logic [9:0]        hfield,
  input  logic [2:0]        depth,
  input  logic              en_bit,
  input  logic              pwr_bit,
  output logic [GEOM_W-1:0] width,
  output logic [GEOM_W-1:0] height,
  output logic [2:0]        bpp,
  output logic              enabled
);

  logic [GEOM_W-1:0] units;
  assign units   = GEOM_W'(wfield) + GEOM_W'(1);
  assign width   = units << 4;
  assign height  = GEOM_W'(hfield) + GEOM_W'(1);
  assign bpp     = depth;
  assign enabled = en_bit & pwr_bit;

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        variant,
  input  logic [IRQ_W-1:0]  irq_event,
  output logic              irq_out,
  output logic [GEOM_W-1:0] act_width,
  output logic [GEOM_W-1:0] act_height,
  output logic [2:0]        bpp_code,
  output logic              disp_en
);

  localparam int IDX_W   = ADDR_W - 2;
  localparam int N_TIM   = 4;
  localparam int BIT_EN  = 0;
  localparam int BIT_PWR = 11;

  logic unused_lo;
  assign unused_lo = ^bus_addr[1:0];

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  sel_t sel;
  lcdc_decode #(.IDX_W(IDX_W)) u_dec (
    .idx     (idx),
    .variant (variant),
    .sel     (sel)
  );

  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] upb_q, lpb_q, ctrl_q;

  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n)                    tim_q[g] <= '0;
      else if (bus_wr && sel.tim[g]) tim_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (sel.upb)  upb_q  <= bus_wdata;
      if (sel.lpb)  lpb_q  <= bus_wdata;
      if (sel.ctrl) ctrl_q <= bus_wdata;
    end
  end

  logic [IRQ_W-1:0] raw_q, mask_q;
  lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (irq_event),
    .clr_we    (bus_wr && sel.clr),
    .clr_bits  (bus_wdata[IRQ_W-1:0]),
    .mask_we   (bus_wr && sel.imask),
    .mask_bits (bus_wdata[IRQ_W-1:0]),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .irq       (irq_out)
  );

  lcdc_geom u_geom (
    .wfield  (tim_q[0][7:2]),
    .hfield  (tim_q[1][9:0]),
    .depth   (ctrl_q[3:1]),
    .en_bit  (ctrl_q[BIT_EN]),
    .pwr_bit (ctrl_q[BIT_PWR]),
    .width   (act_width),
    .height  (act_height),
    .bpp     (bpp_code),
    .enabled (disp_en)
  );

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    for (int i = 0; i < N_TIM; i++) begin
      if (sel.tim[i]) rmux = tim_q[i];
    end
    if (sel.upb || sel.upcur) rmux = upb_q;
    if (sel.lpb || sel.lpcur) rmux = lpb_q;
    if (sel.ctrl)  rmux = ctrl_q;
    if (sel.imask) rmux = DATA_W'(mask_q);
    if (sel.raw)   rmux = DATA_W'(raw_q);
    if (sel.msk)   rmux = DATA_W'(raw_q & mask_q);
    if (sel.id)    rmux = DATA_W'(id_byte(variant == 2'd2, sel.id_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rmux;
  end

endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk
  import lcdc_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-3:0]   bus_idx,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [IRQ_W-1:0]    clr_bits,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [IRQ_W-1:0]    irq_event,
  input logic                irq_out,
  input logic [GEOM_W-1:0]   act_width,
  input logic [GEOM_W-1:0]   act_height,
  input logic [2:0]          bpp_code,
  input logic                disp_en,
  input logic [IRQ_W-1:0]    raw_q,
  input logic [IRQ_W-1:0]    mask_q
);

  localparam int IDX_W = ADDR_W - 2;

  // R4 / R5: decoded outputs move only after a write
  a_r4_geom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(act_width) && $stable(act_height)
                        && $stable(bpp_code) && $stable(disp_en)));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event != '0) |=> ((raw_q & $past(irq_event)) == $past(irq_event)));

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IDX_W'(IDX_CLR) && irq_event == '0)
      |=> ((raw_q & $past(clr_bits)) == '0));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (raw_q != '0 && mask_q != '0));

  a_r9_raw_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_idx == IDX_W'(IDX_RAW) && irq_event == '0) |=> $stable(raw_q));

endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_idx    (bus_addr[ADDR_W-1:2]),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .clr_bits   (bus_wdata[IRQ_W-1:0]),
  .bus_rdata  (bus_rdata),
  .irq_event  (irq_event),
  .irq_out    (irq_out),
  .act_width  (act_width),
  .act_height (act_height),
  .bpp_code   (bpp_code),
  .disp_en    (disp_en),
  .raw_q      (raw_q),
  .mask_q     (mask_q)
);

// File: tb/lcdc_regs_test.sv
module lcdc_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  variant = 2'd0;
  logic [3:0]  irq_event = '0;
  logic        irq_out;
  logic [10:0] act_width, act_height;
  logic [2:0]  bpp_code;
  logic        disp_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcdc_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .variant(variant),
    .irq_event(irq_event), .irq_out(irq_out), .act_width(act_width),
    .act_height(act_height), .bpp_code(bpp_code), .disp_en(disp_en)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(idx << 2); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] b);
    @(negedge clk);
    irq_event = b;
    @(negedge clk);
    irq_event = '0;
  endtask

  function automatic logic [7:0] exp_id(input int v, input int n);
    logic [7:0] tbl [8];
    tbl = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 2 && n == 0) return 8'h11;
    if (v == 2 && n == 2) return 8'h24;
    return tbl[n];
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 width", 32'(act_width), 32'd16);
    chk("R1 height", 32'(act_height), 32'd1);
    chk("R1 bpp", 32'(bpp_code), 32'd0);
    chk("R1 enable", 32'(disp_en), 32'd0);
    chk("R1 irq", 32'(irq_out), 32'd0);
    for (int i = 0; i <= 12; i++) begin
      rd(i, d);
      chk("R1 register zero", d, 32'd0);
    end

    // R2 plain registers and current-address aliases
    for (int i = 0; i < 6; i++) wr(i, 32'hA5000000 + 32'(i * 32'h01010101));
    for (int i = 0; i < 6; i++) begin
      rd(i, d);
      chk("R2 readback", d, 32'hA5000000 + 32'(i * 32'h01010101));
    end
    rd(11, d); chk("R2 upper current", d, 32'hA5000000 + 32'h04040404);
    rd(12, d); chk("R2 lower current", d, 32'hA5000000 + 32'h05050505);

    // R3 layout per variant
    for (int v = 0; v < 4; v++) begin
      int ci, mi;
      variant = 2'(v);
      ci = (v == 0) ? 7 : 6;
      mi = (v == 0) ? 6 : 7;
      wr(ci, 32'h0000080F);
      wr(mi, 32'hFFFFFFF5);
      chk("R3 enable via control slot", 32'(disp_en), 32'd1);
      chk("R3 depth via control slot", 32'(bpp_code), 32'd7);
      rd(ci, d); chk("R3 control read", d, 32'h0000080F);
      rd(mi, d); chk("R3 mask read", d, 32'h5);
      wr(ci, 32'h0); wr(mi, 32'h0);
      chk("R3 control cleared", 32'(disp_en), 32'd0);
    end
    variant = 2'd0;

    // R4 width sweep over all low-byte values
    for (int k = 0; k < 256; k++) begin
      wr(0, 32'hFFFFFF00 | 32'(k));
      chk("R4 width", 32'(act_width), 32'(((k & 32'hFC) + 4) * 4));
    end
    // R4 height sweep over every line count
    for (int j = 0; j < 1024; j++) begin
      logic [31:0] val;
      val = 32'(j) | 32'hFC00_0000 | (32'(j ^ 32'h2AA) << 10);
      wr(1, val);
      chk("R4 height", 32'(act_height), (val & 32'h3FF) + 1);
    end

    // R5 control field sweep
    for (int c = 0; c < 32; c++) begin
      logic [31:0] val;
      val = 32'(c & 15) | (32'((c >> 4) & 1) << 11) | 32'h0000_0770;
      wr(7, val);
      chk("R5 depth", 32'(bpp_code), 32'((c >> 1) & 7));
      chk("R5 enable", 32'(disp_en), 32'((c & 1) & ((c >> 4) & 1)));
    end
    wr(7, 32'h0);

    // R6 / R7 status and mask sweep
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        wr(10, 32'hFFFFFFFF);
        pulse(4'(p));
        wr(6, 32'(m));
        rd(8, d); chk("R6 raw set by events", d, 32'(p));
        rd(9, d); chk("R7 masked status", d, 32'(p & m));
        chk("R7 irq line", 32'(irq_out), 32'((p & m) != 0));
      end
    end
    wr(10, 32'hF); pulse(4'hF);
    wr(10, 32'h5);
    rd(8, d); chk("R6 partial clear", d, 32'hA);
    // R6 event wins over clear in the same cycle
    wr(10, 32'hF);
    @(negedge clk);
    bus_addr = 12'(10 << 2); bus_wdata = 32'hFFFFFFFF; bus_wr = 1'b1; irq_event = 4'h1;
    @(negedge clk);
    bus_wr = 1'b0; irq_event = '0;
    rd(8, d); chk("R6 event beats clear", d, 32'h1);

    // R8 identification window
    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      for (int n = 0; n < 8; n++) begin
        rd(32'h3F8 + n, d);
        chk("R8 id byte", d, 32'(exp_id(v, n)));
      end
    end
    variant = 2'd0;

    // R9 unmapped and read-only locations
    wr(13, 32'hFFFFFFFF); wr(32'h80, 32'hFFFFFFFF); wr(8, 32'hFFFFFFFF);
    wr(9, 32'hFFFFFFFF); wr(32'h3F8, 32'hFFFFFFFF); wr(32'h3F0, 32'hFFFFFFFF);
    rd(13, d);      chk("R9 unmapped read", d, 32'h0);
    rd(32'h80, d);  chk("R9 unmapped read high", d, 32'h0);
    rd(32'h3F0, d); chk("R9 unmapped read near id", d, 32'h0);
    rd(8, d);       chk("R9 raw untouched", d, 32'h1);
    rd(32'h3F8, d); chk("R9 id untouched", d, 32'h10);
    rd(2, d);       chk("R9 timing2 untouched", d, 32'hA5000000 + 32'h02020202);
    rd(4, d);       chk("R9 upper base untouched", d, 32'hA5000000 + 32'h04040404);

    // R10 latency and hold
    wr(3, 32'h12345678);
    rd(3, d);
    chk("R10 read after strobe", d, 32'h12345678);
    wr(3, 32'h0BADF00D);
    @(negedge clk);
    chk("R10 hold without read", bus_rdata, 32'h12345678);
    bus_addr = 12'(3 << 2); bus_rd = 1'b1;
    #1 chk("R10 not before edge", bus_rdata, 32'h12345678);
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 one cycle after strobe", bus_rdata, 32'h0BADF00D);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule